// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Management Bus

This block is a target on an SMBus-style two-wire bus. It gives a host access to a small bank of 8-bit configuration registers. The block oversamples the clock and data lines with the system clock. It detects start, repeated start and stop conditions. It pulls the data line low to acknowledge bytes and to send read data. The data line is open drain: the block only ever asserts a pull-down enable.

A write transfer carries the write address, a starting index, a byte count and then that many data bytes. The bytes land in consecutive registers. A read transfer carries the write address and a starting index, then a repeated start and the read address. The target answers with the byte count held in a count register. It then sends the registers one after another from the starting index until the host refuses a byte. The rest of the chip sees every register through a flat output vector and a one-cycle write strobe per register. The chip supplies the value of the read-only bit positions on an input vector.

Top module: `smb_cfg_target`

## Requirements
- R1: The target acknowledges an address byte of 0xD2 (write) or 0xD3 (read). Any other address byte gets no acknowledge, and every later byte is ignored and not acknowledged until the next start.
- R2: After 0xD2, the next byte is the starting index N and the following byte is the count X. The X data bytes that follow are stored into registers N, N+1, ..., each byte acknowledged, and each stored register pulses its write strobe for one cycle.
- R3: A data byte sent after the X counted bytes is not acknowledged and not stored, and the target then ignores the bus until the next start.
- R4: After 0xD2 and an index N, a repeated start and 0xD3 make the target send the count byte first. It then sends registers N, N+1, ... in ascending order, most significant bit first, one byte per acknowledge from the host.
- R5: When the host does not acknowledge a read byte, the target releases the data line and sends nothing more before the stop.
- R6: The count sent on reads is bits [5:0] of register 12, sent with bits [7:6] as zero. The count resets to 13, and a write of a value above 32 into those bits stores 32. Bits [7:6] of register 12 are plain storage.
- R7: Read-only bits ignore writes and always show the matching bits of the read-only input. These are bits [7:5] of register 0, all of register 7 and bits [7:4] of register 8.
- R8: At reset, registers 2 and 3 hold 0xFF, register 4 holds 0xF9, register 8 holds 0x02 in its writable bits and register 12 holds 0x0D. All other writable bits are 0, and the data line is released.
- R9: An index of 13 or above reads back as 0x00. Data bytes written to such an index are acknowledged but discarded, with no write strobe.
- R10: The target changes its data-line drive only while the sampled clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired value) |
| sda_oe | output | 1 | High to pull the data line low |
| ro_in | input | NUM_REGS*8 | Values shown in the read-only bit positions, register k at bits [8k+7:8k] |
| cfg_q | output | NUM_REGS*8 | Current register contents, register k at bits [8k+7:8k] |
| wr_stb | output | NUM_REGS | One-cycle pulse per register stored by the host |

## Verification
The bench sends a data byte past the count; a design that kept counting would acknowledge it and corrupt the next register. It writes across the end of the bank into index 13 and beyond, where a design without a range check would alias onto low registers or emit strobes. It writes 0x3F into the count field, which an unclamped design would report as 63. It also writes over read-only bits, which a design that stored them would echo back. Reads end with a host refusal. A target that kept driving after it would hold the data line low through the stop.

// File: rtl/smb_pkg.sv
package smb_pkg;

  localparam logic [7:0] ADDR_WR = 8'hD2;
  localparam logic [7:0] ADDR_RD = 8'hD3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_WDATA,
    PH_RDATA
  } smb_phase_e;

  // Reset value of the writable bits of register idx.
  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      2, 3:    return 8'hFF;
      4:       return 8'hF9;
      8:       return 8'h02;
      12:      return 8'h0D;
      default: return 8'h00;
    endcase
  endfunction

  // Bits of register idx taken from the read-only input.
  function automatic logic [7:0] reg_ro_mask(input int idx);
    case (idx)
      0:       return 8'hE0;
      7:       return 8'hFF;
      8:       return 8'hF0;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sampler.sv
module smb_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
  logic                   scl_prev_q, sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_in};
      sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_in};
      scl_prev_q <= scl_sync_q[SYNC_STAGES-1];
      sda_prev_q <= sda_sync_q[SYNC_STAGES-1];
    end
  end

  assign scl_lvl   = scl_sync_q[SYNC_STAGES-1];
  assign sda_lvl   = sda_sync_q[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev_q;
  assign scl_fall  = ~scl_lvl & scl_prev_q;
  assign start_det = scl_lvl & scl_prev_q & sda_prev_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev_q & ~sda_prev_q & sda_lvl;

endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank
  import smb_pkg::*;
#(
  parameter int NUM_REGS = 13,
  parameter int CNT_IDX  = 12,
  parameter int CNT_MAX  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_idx,
  output logic [7:0]            rd_data,
  input  logic [NUM_REGS*8-1:0] ro_in,
  output logic [NUM_REGS*8-1:0] cfg_q,
  output logic [NUM_REGS-1:0]   wr_stb,
  output logic [5:0]            cnt_val
);

  localparam logic [5:0] CNT_CAP = 6'(CNT_MAX);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] DEF = reg_default(i);
    localparam logic [7:0] MSK = reg_ro_mask(i);
    logic [7:0] store_q, store_d;
    logic       stb_q;
    logic       hit;

    assign hit = wr_en && (wr_idx == 8'(i));

    always_comb begin
      store_d = wr_data;
      if ((i == CNT_IDX) && (wr_data[5:0] > CNT_CAP)) store_d[5:0] = CNT_CAP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        store_q <= DEF;
        stb_q   <= 1'b0;
      end else begin
        stb_q <= hit;
        if (hit) store_q <= store_d;
      end
    end

    assign cfg_q[i*8 +: 8] = (store_q & ~MSK) | (ro_in[i*8 +: 8] & MSK);
    assign wr_stb[i]       = stb_q;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_idx == 8'(k)) rd_data = cfg_q[k*8 +: 8];
    end
  end

  assign cnt_val = cfg_q[CNT_IDX*8 +: 6];

  // R6: the count field never exceeds its cap
  a_r6_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_val <= CNT_CAP);

  // R9: a write past the bank produces no strobe
  a_r9_no_stb_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_idx) >= NUM_REGS)) |=> (wr_stb == '0));

  // R2: at most one register is stored per cycle
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));

endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
  import smb_pkg::*;
#(
  parameter int NUM_REGS = 13,
  parameter int CNT_IDX  = 12,
  parameter int CNT_MAX  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_oe,
  input  logic [NUM_REGS*8-1:0] ro_in,
  output logic [NUM_REGS*8-1:0] cfg_q,
  output logic [NUM_REGS-1:0]   wr_stb
);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  smb_line_sampler #(.SYNC_STAGES(2)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  smb_phase_e phase_q, phase_d, next_q, next_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] shift_q, shift_d, ptr_q, ptr_d, left_q, left_d, tx_q, tx_d;
  logic       ack_q, ack_d, tx_en_q, tx_en_d, nack_q, nack_d;
  logic       wr_en;
  logic [7:0] rd_data;
  logic [5:0] cnt_val;

  smb_cfg_bank #(.NUM_REGS(NUM_REGS), .CNT_IDX(CNT_IDX), .CNT_MAX(CNT_MAX)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr_q), .wr_data(shift_q),
    .rd_idx(ptr_q), .rd_data(rd_data), .ro_in(ro_in), .cfg_q(cfg_q),
    .wr_stb(wr_stb), .cnt_val(cnt_val)
  );

  always_comb begin
    phase_d = phase_q;  next_d  = next_q;  cnt_d = cnt_q;  shift_d = shift_q;
    ptr_d   = ptr_q;    left_d  = left_q;  tx_d  = tx_q;   ack_d   = ack_q;
    tx_en_d = tx_en_q;  nack_d  = nack_q;  wr_en = 1'b0;
    if (start_det) begin
      phase_d = PH_ADDR; cnt_d = 4'd0; ack_d = 1'b0; tx_en_d = 1'b0;
    end else if (stop_det) begin
      phase_d = PH_IDLE; cnt_d = 4'd0; ack_d = 1'b0; tx_en_d = 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (scl_rise) begin
        if (cnt_q < 4'd8) begin
          cnt_d = cnt_q + 4'd1;
          if (phase_q != PH_RDATA) shift_d = {shift_q[6:0], sda_lvl};
        end else if (cnt_q == 4'd8) begin
          cnt_d = 4'd9;
          if (phase_q == PH_RDATA) nack_d = sda_lvl;
        end
      end else if (scl_fall) begin
        if (phase_q == PH_RDATA) begin
          if (cnt_q == 4'd8) begin
            tx_en_d = 1'b0;
          end else if (cnt_q == 4'd9) begin
            if (nack_q) begin
              phase_d = PH_IDLE;
            end else begin
              tx_d = rd_data; ptr_d = ptr_q + 8'd1; tx_en_d = 1'b1; cnt_d = 4'd0;
            end
          end else if (cnt_q != 4'd0) begin
            tx_d = {tx_q[6:0], 1'b0};
          end
        end else if (cnt_q == 4'd8) begin
          case (phase_q)
            PH_ADDR: begin
              if (shift_q == ADDR_WR) begin
                ack_d = 1'b1; next_d = PH_INDEX;
              end else if (shift_q == ADDR_RD) begin
                ack_d = 1'b1; next_d = PH_RDATA;
              end else begin
                phase_d = PH_IDLE;
              end
            end
            PH_INDEX: begin ptr_d = shift_q; ack_d = 1'b1; next_d = PH_COUNT; end
            PH_COUNT: begin left_d = shift_q; ack_d = 1'b1; next_d = PH_WDATA; end
            PH_WDATA: begin
              if (left_q != 8'd0) begin
                wr_en = 1'b1; ptr_d = ptr_q + 8'd1; left_d = left_q - 8'd1;
                ack_d = 1'b1; next_d = PH_WDATA;
              end else begin
                phase_d = PH_IDLE;
              end
            end
            default: phase_d = PH_IDLE;
          endcase
        end else if (cnt_q == 4'd9) begin
          ack_d = 1'b0; cnt_d = 4'd0; phase_d = next_q;
          if (next_q == PH_RDATA) begin
            tx_d = {2'b00, cnt_val}; tx_en_d = 1'b1; nack_d = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE; next_q <= PH_IDLE; cnt_q <= 4'd0; shift_q <= 8'h00;
      ptr_q   <= 8'h00;   left_q <= 8'h00;   tx_q  <= 8'h00;
      ack_q   <= 1'b0;    tx_en_q <= 1'b0;   nack_q <= 1'b0;
    end else begin
      phase_q <= phase_d; next_q <= next_d; cnt_q <= cnt_d; shift_q <= shift_d;
      ptr_q   <= ptr_d;   left_q <= left_d; tx_q  <= tx_d;
      ack_q   <= ack_d;   tx_en_q <= tx_en_d; nack_q <= nack_d;
    end
  end

  assign sda_oe = ack_q | (tx_en_q & ~tx_q[7]);

  // R1: an acknowledge in the address phase only follows an own address
  a_r1_ack_own_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_q) && phase_q == PH_ADDR) |-> (shift_q == ADDR_WR || shift_q == ADDR_RD));

  // R5: an idle target never holds the data line
  a_r5_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> !sda_oe);

  // R10: drive changes only follow a low sampled clock
  a_r10_drive_moves_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_lvl));

endmodule

// File: tb/smb_cfg_target_test.sv
module smb_cfg_target_test;
  localparam int NR = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_host = 1'b1, sda_host = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [NR*8-1:0] ro_in, cfg_q;
  logic [NR-1:0]   wr_stb;

  int n_chk = 0, n_err = 0, stb_total = 0, r10_viol = 0;
  logic [7:0] model [0:NR-1];
  logic [7:0] wbuf  [0:7];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] got_byte;
  logic       got_stb = 1'b0;
  logic       prev_oe = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_host & ~sda_oe;

  smb_cfg_target uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_host), .sda_in(sda_line),
    .sda_oe(sda_oe), .ro_in(ro_in), .cfg_q(cfg_q), .wr_stb(wr_stb)
  );

  function automatic logic [7:0] msk(input int j);
    case (j) 0: return 8'hE0; 7: return 8'hFF; 8: return 8'hF0; default: return 8'h00; endcase
  endfunction
  function automatic logic [7:0] ro_val(input int j);
    return 8'(8'h93 ^ (j * 37));
  endfunction
  function automatic logic [7:0] exp_reg(input int j);
    if (j >= NR) return 8'h00;
    return (model[j] & ~msk(j)) | (ro_val(j) & msk(j));
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) if (rst_n) stb_total += $countones(wr_stb);

  // R10 monitor: drive may only move while the host holds the clock low
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl_host) r10_viol++;
    prev_oe <= sda_oe;
  end

  // scoreboard monitor for read data
  always @(posedge got_stb) begin
    if (exp_q.size() == 0) begin
      check(1'b0, "R4 unexpected read byte", got_byte, 8'h00);
    end else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(got_byte == e, t, got_byte, e);
    end
  end

  task automatic wq(); repeat (4) @(negedge clk); endtask

  task automatic bus_start();
    sda_host = 1'b1; scl_host = 1'b1; wq(); wq();
    sda_host = 1'b0; wq(); wq();
    scl_host = 1'b0;
  endtask
  task automatic bus_rstart();
    wq(); sda_host = 1'b1; wq(); scl_host = 1'b1; wq(); wq();
    sda_host = 1'b0; wq(); wq(); scl_host = 1'b0;
  endtask
  task automatic bus_stop();
    wq(); sda_host = 1'b0; wq(); scl_host = 1'b1; wq(); wq();
    sda_host = 1'b1; wq(); wq();
  endtask
  task automatic bit_out(input logic b);
    wq(); sda_host = b; wq(); scl_host = 1'b1; wq(); wq(); scl_host = 1'b0;
  endtask
  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    wq(); sda_host = 1'b1; wq(); scl_host = 1'b1; wq();
    acked = (sda_line == 1'b0);
    wq(); scl_host = 1'b0;
  endtask
  task automatic recv_byte(input logic refuse);
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      wq(); sda_host = 1'b1; wq(); scl_host = 1'b1; wq();
      b[i] = sda_line;
      wq(); scl_host = 1'b0;
    end
    got_byte = b; got_stb = 1'b1;
    @(negedge clk); got_stb = 1'b0;
    bit_out(refuse);
  endtask

  task automatic model_write(input int j, input logic [7:0] d);
    if (j < NR) begin
      model[j] = d;
      if (j == 12 && d[5:0] > 6'd32) model[j][5:0] = 6'd32;
    end
  endtask

  task automatic blk_write(input logic [7:0] idx, input logic [7:0] cnt, input int nsend);
    bit a;
    bus_start();
    send_byte(8'hD2, a); check(a, "R1 write address acknowledged", 8'(a), 8'h01);
    send_byte(idx, a);   check(a, "R2 index acknowledged", 8'(a), 8'h01);
    send_byte(cnt, a);   check(a, "R2 count acknowledged", 8'(a), 8'h01);
    for (int k = 0; k < nsend; k++) begin
      send_byte(wbuf[k], a);
      if (k < int'(cnt)) begin
        check(a, "R2 data byte acknowledged", 8'(a), 8'h01);
        model_write(int'(idx) + k, wbuf[k]);
      end else begin
        check(!a, "R3 byte beyond count not acknowledged", 8'(a), 8'h00);
      end
    end
    bus_stop();
  endtask

  task automatic blk_read(input logic [7:0] idx, input int n);
    bit a;
    bus_start();
    send_byte(8'hD2, a); check(a, "R1 write address acknowledged", 8'(a), 8'h01);
    send_byte(idx, a);   check(a, "R4 index acknowledged", 8'(a), 8'h01);
    bus_rstart();
    send_byte(8'hD3, a); check(a, "R1 read address acknowledged", 8'(a), 8'h01);
    exp_q.push_back({2'b00, model[12][5:0]}); tag_q.push_back("R6 count byte");
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(exp_reg(int'(idx) + k));
      tag_q.push_back((int'(idx) + k >= NR) ? "R9 read past bank" : "R4 read register");
    end
    recv_byte(n == 0);
    for (int k = 0; k < n; k++) recv_byte(k == n - 1);
    wq(); wq(); wq();
    check(sda_oe == 1'b0, "R5 line released after refusal", 8'(sda_oe), 8'h00);
    bus_stop();
    check(exp_q.size() == 0, "R4 all read bytes delivered", 8'(exp_q.size()), 8'h00);
  endtask

  task automatic check_bank(input string req);
    for (int j = 0; j < NR; j++)
      check(cfg_q[j*8 +: 8] == exp_reg(j), req, cfg_q[j*8 +: 8], exp_reg(j));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int s0;
    bit a;
    for (int j = 0; j < NR; j++) begin
      ro_in[j*8 +: 8] = ro_val(j);
      model[j] = 8'h00;
    end
    model[2] = 8'hFF; model[3] = 8'hFF; model[4] = 8'hF9; model[8] = 8'h02; model[12] = 8'h0D;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8 reset contents, R7 read-only view
    check_bank("R8 reset value");
    check(sda_oe == 1'b0, "R8 line released at reset", 8'(sda_oe), 8'h00);

    // R2 plain block write
    s0 = stb_total;
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wbuf[2] = 8'h3C;
    blk_write(8'd2, 8'd3, 3);
    check_bank("R2 block write contents");
    check(stb_total - s0 == 3, "R2 strobe count", 8'(stb_total - s0), 8'd3);

    // R4 block read with count first
    blk_read(8'd2, 3);

    // R7 writes over read-only bits
    wbuf[0] = 8'hFF; blk_write(8'd0, 8'd1, 1);
    wbuf[0] = 8'h00; blk_write(8'd7, 8'd1, 1);
    wbuf[0] = 8'h0F; blk_write(8'd8, 8'd1, 1);
    check_bank("R7 read-only bits unchanged");

    // R1 foreign address ignored until next start
    s0 = stb_total;
    bus_start();
    send_byte(8'hA0, a); check(!a, "R1 foreign address not acknowledged", 8'(a), 8'h00);
    send_byte(8'h05, a); check(!a, "R1 later byte ignored", 8'(a), 8'h00);
    send_byte(8'h01, a); check(!a, "R1 later byte ignored", 8'(a), 8'h00);
    bus_stop();
    check(stb_total == s0, "R1 no write after foreign address", 8'(stb_total - s0), 8'h00);
    check_bank("R1 bank unchanged");

    // R3 byte beyond the count
    s0 = stb_total;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    blk_write(8'd5, 8'd1, 3);
    check_bank("R3 only counted byte stored");
    check(stb_total - s0 == 1, "R3 strobe count", 8'(stb_total - s0), 8'd1);

    // R9 and R6: write across the end of the bank, count clamps
    s0 = stb_total;
    wbuf[0] = 8'h44; wbuf[1] = 8'h3F; wbuf[2] = 8'h77; wbuf[3] = 8'h88;
    blk_write(8'd11, 8'd4, 4);
    check(stb_total - s0 == 2, "R9 no strobe past bank", 8'(stb_total - s0), 8'd2);
    check(cfg_q[12*8 +: 8] == 8'h20, "R6 count clamped to 32", cfg_q[12*8 +: 8], 8'h20);
    check_bank("R9 bank after write past end");
    blk_read(8'd11, 3);

    // R6 upper bits of the count register are storage, not count
    wbuf[0] = 8'hC5; blk_write(8'd12, 8'd1, 1);
    check(cfg_q[12*8 +: 8] == 8'hC5, "R6 register keeps upper bits", cfg_q[12*8 +: 8], 8'hC5);
    blk_read(8'd0, 2);

    // R9 read fully outside the bank
    blk_read(8'd20, 2);

    check(r10_viol == 0, "R10 drive changed with clock high", 8'(r10_viol), 8'h00);
    finish_run();
  end

endmodule